// File: doc/BRIEF.md
# In-band request arbiter for a two-wire shared serial bus

This block sits on the target side of a two-wire bus with a clock line and an open-drain data line. When its owner raises `req`, the block waits for a free bus and then pulls the data line low while the clock line is still high. That creates a START on its own, which asks the controller for service, for example an interrupt or a join request. The controller answers by running the clock. The block then sends its 7-bit address one bit per clock, most significant bit first. Other devices may contend for the bus at the same time, and the wired-AND of the data line settles the contest.

Both bus lines come in raw. They pass through synchronisers, and edges are found in the system clock domain. The data line is only ever pulled low through `sda_oe` and never driven high, so a 0 always overrides a 1. A loss of arbitration, a win, or a STOP from the controller ends the block's part in the frame. A request that is still pending is tried again once the bus is free.

Top module: `inband_req_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `sda_oe`, `won`, `lost` and `busy` are all 0.
- R2: With `req` high, the bus free (no START since reset or since the last STOP) and both synchronised lines high, the block raises `sda_oe` and `busy` on the next clock. It holds `sda_oe` high until it sees the synchronised clock line fall.
- R3: After a START it did not cause (data falling while clock is high), the block keeps `sda_oe` at 0 until a STOP, whatever `req` does.
- R4: The address goes out most significant bit first, one bit per clock-low phase. `sda_oe`=1 sends a 0 bit and `sda_oe`=0 sends a 1 bit. Inside a frame, `sda_oe` changes only after a synchronised clock fall and never while the clock is high.
- R5: On each synchronised clock rise the block samples the data line. If it sent a 1 and reads a 0, it gives a one-cycle `lost` pulse and keeps `sda_oe` at 0 for the rest of the frame.
- R6: If the seventh bit is sampled without a loss, the block releases the line at the next clock fall and gives a one-cycle `won` pulse in the same cycle.
- R7: A STOP (data rising while clock is high) seen in any state returns the block to idle on the next clock. If `req` is still high, a new START follows as soon as the bus is idle.
- R8: Against a contender, the bus carries the lower of the two addresses, and the block wins exactly when its own address is the lower one.
- R9: `busy` is high from the cycle the request is taken until the block returns to idle on a STOP.
- R10: `own_addr` is captured when the request is taken. Later changes have no effect on the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must give several cycles per bus clock-high phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| req | input | 1 | Level request for service; kept high until served |
| own_addr | input | ADDR_W | Address used in arbitration |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| won | output | 1 | One-cycle pulse: arbitration won |
| lost | output | 1 | One-cycle pulse: arbitration lost |
| busy | output | 1 | Block is taking part in a frame |

## Verification
Some rules hold on every cycle, and the assertions watch those. `sda_oe` stays steady while the synchronised clock stays high inside a frame. `won` and `lost` are single-cycle pulses and never come together, and both leave the line released. The block only becomes busy on a free bus. A STOP always sends a busy block back to idle. Other behaviour depends on what happens on the bus, so only the bench scenarios can show it. These are the bit order seen on the wired line, the choice of the lower address as winner (including a contest decided only at the last bit), silence during another device's frame, the retry after an aborted frame, and that a changed address is ignored mid-frame. The bench checks these against a behavioural model compared on every clock.

// File: rtl/inband_req_arbiter.sv
module inband_req_arbiter #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              req,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              sda_oe,
  output logic              won,
  output logic              lost,
  output logic              busy
);

  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(ADDR_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ARB, S_LAST, S_DONE, S_BACK
  } st_t;

  st_t                    st;
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic                   scl_q, sda_q;
  logic                   bus_free;
  logic [ADDR_W-1:0]      addr_q;
  logic [IDX_W-1:0]       idx;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, drv_bit;

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
  assign drv_bit   = (st == S_ARB) || (st == S_LAST);

  assign sda_oe = (st == S_START) | (drv_bit & ~addr_q[idx]);
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bus_free <= 1'b1;
      addr_q   <= '0;
      idx      <= TOP_BIT;
      won      <= 1'b0;
      lost     <= 1'b0;
    end else begin
      won  <= 1'b0;
      lost <= 1'b0;
      if (stop_det)       bus_free <= 1'b1;
      else if (start_det) bus_free <= 1'b0;

      case (st)
        S_IDLE:
          if (req && bus_free && scl_s && sda_s) begin
            st     <= S_START;
            addr_q <= own_addr;
            idx    <= TOP_BIT;
          end
        S_START:
          if (stop_det)      st <= S_IDLE;
          else if (scl_fall) st <= S_ARB;
        S_ARB:
          if (stop_det) st <= S_IDLE;
          else if (scl_rise) begin
            if (addr_q[idx] && !sda_s) begin
              st   <= S_BACK;
              lost <= 1'b1;
            end else if (idx == '0) begin
              st <= S_LAST;
            end
          end else if (scl_fall) begin
            idx <= idx - 1'b1;
          end
        S_LAST:
          if (stop_det) st <= S_IDLE;
          else if (scl_fall) begin
            st  <= S_DONE;
            won <= 1'b1;
          end
        S_DONE, S_BACK:
          if (stop_det) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/inband_req_arbiter_chk.sv
module inband_req_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_det,
  input logic bus_free,
  input logic sda_oe,
  input logic won,
  input logic lost,
  input logic busy
);

  p_won_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    won |=> !won);

  p_won_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    won |-> !sda_oe);

  p_lost_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !lost);

  p_lost_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (!sda_oe && !won));

  p_drive_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && $past(busy)) |-> $stable(sda_oe));

  p_start_on_free_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(bus_free));

  p_stop_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && busy) |=> !busy);

endmodule

bind inband_req_arbiter inband_req_arbiter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .bus_free (bus_free),
  .sda_oe   (sda_oe),
  .won      (won),
  .lost     (lost),
  .busy     (busy)
);

// File: tb/inband_req_arbiter_bench.sv
module inband_req_arbiter_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_raw = 1'b1;
  logic ctrl_oe = 1'b0;
  logic oth_oe = 1'b0;
  logic req = 1'b0;
  logic [6:0] own_addr = '0;
  logic sda_oe, won, lost, busy;
  logic sda_raw;

  int tests = 0, fails = 0;
  int won_cnt = 0, lost_cnt = 0;
  bit chk_on = 1'b0, mon_on = 1'b0, dut_drove = 1'b0;

  assign sda_raw = !(sda_oe | ctrl_oe | oth_oe);

  always #4 clk = ~clk;

  inband_req_arbiter u_inband_req_arbiter (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_raw), .sda_in(sda_raw),
    .req(req), .own_addr(own_addr),
    .sda_oe(sda_oe), .won(won), .lost(lost), .busy(busy)
  );

  // behavioural reference model
  logic [3:0] hs = '1, hd = '1;
  int m_st = 0, m_bit = 6;
  bit m_free = 1'b1;
  logic [6:0] m_addr = '0;
  bit e_oe = 0, e_won = 0, e_lost = 0, e_busy = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hs = '1; hd = '1; m_st = 0; m_bit = 6; m_free = 1; m_addr = '0;
      e_won = 0; e_lost = 0;
    end else begin
      bit cs, ps, cd, pd, stp, sta, rise, fall;
      hs = {hs[2:0], scl_raw};
      hd = {hd[2:0], sda_raw};
      cs = hs[2]; ps = hs[3]; cd = hd[2]; pd = hd[3];
      sta  = cs && ps && pd && !cd;
      stp  = cs && ps && !pd && cd;
      rise = cs && !ps;
      fall = !cs && ps;
      e_won = 0; e_lost = 0;
      if (m_st == 0) begin
        if (req && m_free && cs && cd) begin m_st = 1; m_addr = own_addr; m_bit = 6; end
      end else if (stp) begin
        m_st = 0;
      end else if (m_st == 1) begin
        if (fall) m_st = 2;
      end else if (m_st == 2) begin
        if (rise) begin
          if (m_addr[m_bit] && !cd) begin m_st = 4; e_lost = 1; end
          else if (m_bit == 0) m_st = 5;
        end else if (fall) m_bit = m_bit - 1;
      end else if (m_st == 5) begin
        if (fall) begin m_st = 3; e_won = 1; end
      end
      if (stp) m_free = 1; else if (sta) m_free = 0;
    end
    e_oe   = (m_st == 1) || ((m_st == 2 || m_st == 5) && !m_addr[m_bit]);
    e_busy = (m_st != 0);
  end

  always @(negedge clk) begin
    if (won) won_cnt++;
    if (lost) lost_cnt++;
    if (mon_on && sda_oe) dut_drove = 1'b1;
    if (chk_on) begin
      bit bad;
      bad = 0;
      tests++;
      if (sda_oe !== e_oe) begin bad = 1; $display("FAIL R4 sda_oe got %0d exp %0d @%0t", sda_oe, e_oe, $time); end
      if (won !== e_won)   begin bad = 1; $display("FAIL R6 won got %0d exp %0d @%0t", won, e_won, $time); end
      if (lost !== e_lost) begin bad = 1; $display("FAIL R5 lost got %0d exp %0d @%0t", lost, e_lost, $time); end
      if (busy !== e_busy) begin bad = 1; $display("FAIL R9 busy got %0d exp %0d @%0t", busy, e_busy, $time); end
      if (bad) fails++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string rq, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", rq, got, exp);
    end
  endtask

  // one controller-clocked frame; oth_* models a second contender
  task automatic run_frame(input logic [6:0] oth_addr, input bit oth_join,
                           input bit oth_starts, input int nbits,
                           input bit drop_req, input bit req_mid,
                           input bit addr_swap, output logic [6:0] seen);
    bit oth_in;
    seen = '0;
    if (oth_starts) begin
      oth_oe = 1'b1;
    end else begin
      for (int i = 0; i < 60 && sda_raw; i++) tick(1);
      check("R2 start seen on bus", sda_raw, 0);
      if (oth_join) oth_oe = 1'b1;
    end
    oth_in = oth_join || oth_starts;
    mon_on = oth_starts;
    tick(H);
    if (req_mid) req = 1'b1;
    for (int b = 6; b > 6 - nbits; b--) begin
      scl_raw = 1'b0;
      tick(2);
      oth_oe = oth_in && !oth_addr[b];
      if (addr_swap) own_addr = ~own_addr;
      tick(H);
      scl_raw = 1'b1;
      tick(2);
      seen[b] = sda_raw;
      if (oth_in && oth_addr[b] && !sda_raw) oth_in = 0;
      tick(H);
    end
    scl_raw = 1'b0;
    tick(2);
    oth_oe = 1'b0;
    ctrl_oe = 1'b1;
    if (drop_req) req = 1'b0;
    tick(H);
    scl_raw = 1'b1;
    tick(H);
    mon_on = 1'b0;
    ctrl_oe = 1'b0;
    tick(H);
  endtask

  task automatic solo(input logic [6:0] a, input string rq);
    logic [6:0] seen;
    int w0;
    w0 = won_cnt;
    own_addr = a; req = 1'b1;
    run_frame(7'h00, 0, 0, 7, 1, 0, 0, seen);
    check({rq, " bits on bus"}, seen, a);
    check({rq, " won pulse"}, won_cnt - w0, 1);
  endtask

  task automatic contest(input logic [6:0] mine, input logic [6:0] theirs, input string rq);
    logic [6:0] seen;
    int w0, l0;
    w0 = won_cnt; l0 = lost_cnt;
    own_addr = mine; req = 1'b1;
    run_frame(theirs, 1, 0, 7, 1, 0, 0, seen);
    check({rq, " lower address on bus"}, seen, (mine < theirs) ? mine : theirs);
    check({rq, " won count"}, won_cnt - w0, (mine < theirs) ? 1 : 0);
    check({rq, " lost count"}, lost_cnt - l0, (mine < theirs) ? 0 : 1);
  endtask

  task automatic main_seq;
    logic [6:0] seen;
    int w0;
    tick(3);
    chk_on = 1'b1;
    check("R1 sda_oe in reset", sda_oe, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 won/lost in reset", won | lost, 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 idle after reset", {sda_oe, won, lost, busy}, 0);
    tick(4);

    solo(7'h2A, "R4");
    solo(7'h7F, "R6 all ones");
    solo(7'h00, "R4 all zeros");

    contest(7'h55, 7'h15, "R8 R5 lose early");
    contest(7'h31, 7'h70, "R8 win");
    contest(7'h0B, 7'h0A, "R5 lose last bit");
    contest(7'h0A, 7'h0B, "R6 win last bit");

    // R10: address changed after acceptance
    own_addr = 7'h31; req = 1'b1;
    run_frame(7'h00, 0, 0, 7, 1, 0, 1, seen);
    check("R10 captured address on bus", seen, 7'h31);

    // R3: foreign START, request raised inside that frame
    own_addr = 7'h22; dut_drove = 1'b0;
    run_frame(7'h40, 0, 1, 7, 0, 1, 0, seen);
    check("R3 silent in foreign frame", dut_drove, 0);
    check("R3 retry after STOP busy", busy, 1);
    check("R3 retry after STOP drives", sda_raw, 0);
    w0 = won_cnt;
    run_frame(7'h00, 0, 0, 7, 1, 0, 0, seen);
    check("R3 retried frame bits", seen, 7'h22);
    check("R3 retried frame won", won_cnt - w0, 1);

    // R7: STOP mid-arbitration, request kept
    own_addr = 7'h5B; req = 1'b1;
    run_frame(7'h00, 0, 0, 3, 0, 0, 0, seen);
    check("R7 restart after abort busy", busy, 1);
    check("R7 restart after abort drives", sda_raw, 0);
    w0 = won_cnt;
    run_frame(7'h00, 0, 0, 7, 1, 0, 0, seen);
    check("R7 retry bits", seen, 7'h5B);
    check("R7 retry won", won_cnt - w0, 1);
    check("R9 idle at end", busy, 0);
    tick(10);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule